// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands into a signed 32-bit product and adds that product to a 64-bit accumulator. The accumulator is held as two 32-bit words, a high word and a low word. Each cycle in which the operand strobe is high performs one multiply-accumulate. Results appear on the accumulator outputs one clock later, and operations may follow each other on consecutive cycles.

A mode bit, sampled with each operation, selects how the product is accumulated. In wrap mode the product, sign-extended, is added to the full 64-bit accumulator. In saturating mode only the low word takes the sum. If that sum overflows the signed 32-bit range, the low word is clamped to the limit on the side of the product's sign, and bit 0 of the high word is set as a sticky overflow flag. A clear input zeroes both words, which also removes the flag. A load input writes both words from the load inputs.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset is asserted (active low), both accumulator words read zero.
- R2: In wrap mode (sat_mode = 0) a strobed operation replaces the 64-bit value {acc_hi, acc_lo} with that value plus the signed product of op_a and op_b, sign-extended to 64 bits, modulo 2^64. The high word therefore takes the carry out of the low word and the product's sign extension.
- R3: In saturating mode (sat_mode = 1) without overflow, acc_lo becomes acc_lo plus the signed product, and acc_hi is left unchanged.
- R4: In saturating mode, a positive product whose addition overflows past the largest signed 32-bit value leaves acc_lo = 0x7FFFFFFF. It sets acc_hi bit 0 and leaves acc_hi bits 31..1 unchanged.
- R5: In saturating mode, a negative product whose addition overflows past the smallest signed 32-bit value leaves acc_lo = 0x80000000. It sets acc_hi bit 0 and leaves acc_hi bits 31..1 unchanged.
- R6: Once set, acc_hi bit 0 stays set through later saturating operations and idle cycles until a clear or a load.
- R7: acc_clr zeroes both words on the next clock edge. It takes priority over acc_load and op_valid.
- R8: acc_load writes load_hi into acc_hi and load_lo into acc_lo on the next clock edge. It takes priority over op_valid.
- R9: In a cycle with op_valid, acc_clr and acc_load all low, both words hold their values whatever the operand and mode inputs carry.
- R10: Each strobed operation is visible on the outputs after the next rising edge. Strobes on consecutive cycles each accumulate once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand strobe: perform one multiply-accumulate |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| sat_mode | input | 1 | 1 = saturating mode, 0 = wrap mode |
| acc_clr | input | 1 | Zero both accumulator words |
| acc_load | input | 1 | Load both accumulator words |
| load_hi | input | 32 | Value written to the high word on load |
| load_lo | input | 32 | Value written to the low word on load |
| acc_hi | output | 32 | High accumulator word; bit 0 is the sticky flag in saturating mode |
| acc_lo | output | 32 | Low accumulator word |

## Verification
The hardest state to reach from the ports is a saturating overflow toward the negative limit. A single 16x16 product cannot carry a cleared accumulator past -2^31. The bench therefore uses the load path to preset the low word just above the negative limit, with a recognisable pattern in the high word, and then applies 0x8000 times 0x7FFF. That shows the clamp and that the upper high-word bits are untouched. The positive side is reached by accumulating 0x8000 times 0x8000 twice from zero. A small negative product then shows that the flag survives an operation that does not overflow.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic {
      MODE_WRAP = 1'b0,
      MODE_SAT  = 1'b1
   } acc_mode_e;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_MAC   = 2'd3
   } acc_act_e;

   function automatic acc_act_e pick_action(input logic clr, input logic load, input logic valid);
      if (clr)        return ACT_CLEAR;
      else if (load)  return ACT_LOAD;
      else if (valid) return ACT_MAC;
      else            return ACT_HOLD;
   endfunction

endpackage

// File: rtl/mac_prod.sv
module mac_prod #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 32
) (
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic [ACC_W-1:0] prod_x,
   output logic             prod_neg
);
   localparam int PROD_W = 2 * OP_W;

   logic signed [PROD_W-1:0] prod;

   assign prod = PROD_W'($signed(op_a)) * PROD_W'($signed(op_b));

   generate
      if (ACC_W > PROD_W) begin : g_ext
         assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end else begin : g_exact
         assign prod_x = prod;
      end
   endgenerate

   assign prod_neg = prod[PROD_W-1];

endmodule

// File: rtl/mac_lo_add.sv
module mac_lo_add #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] lo_old,
   input  logic [ACC_W-1:0] prod_x,
   output logic [ACC_W-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W:0] wide;

   assign wide  = {1'b0, lo_old} + {1'b0, prod_x};
   assign sum   = wide[ACC_W-1:0];
   assign carry = wide[ACC_W];
   assign ovf   = (prod_x[MSB] == lo_old[MSB]) && (sum[MSB] != prod_x[MSB]);

endmodule

// File: rtl/mac_acc_regs.sv
module mac_acc_regs
   import mac_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             valid,
   input  logic             sat_mode,
   input  logic [ACC_W-1:0] load_hi,
   input  logic [ACC_W-1:0] load_lo,
   input  logic [ACC_W-1:0] sum,
   input  logic             carry,
   input  logic             ovf,
   input  logic             prod_neg,
   output logic [ACC_W-1:0] acc_hi,
   output logic [ACC_W-1:0] acc_lo
);
   localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] ONE     = ACC_W'(1);

   acc_act_e  act;
   acc_mode_e mode;
   logic [ACC_W-1:0] hi_nxt, lo_nxt, hi_mac, lo_mac;

   assign act  = pick_action(clr, load, valid);
   assign mode = acc_mode_e'(sat_mode);

   always_comb begin
      hi_mac = acc_hi;
      lo_mac = sum;
      if (mode == MODE_SAT) begin
         if (ovf) begin
            hi_mac = acc_hi | ONE;
            lo_mac = prod_neg ? NEG_LIM : POS_LIM;
         end
      end else begin
         hi_mac = acc_hi + {ACC_W{prod_neg}} + ACC_W'(carry);
      end
   end

   always_comb begin
      unique case (act)
         ACT_CLEAR: begin hi_nxt = '0;      lo_nxt = '0;      end
         ACT_LOAD:  begin hi_nxt = load_hi; lo_nxt = load_lo; end
         ACT_MAC:   begin hi_nxt = hi_mac;  lo_nxt = lo_mac;  end
         default:   begin hi_nxt = acc_hi;  lo_nxt = acc_lo;  end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi <= '0;
         acc_lo <= '0;
      end else begin
         acc_hi <= hi_nxt;
         acc_lo <= lo_nxt;
      end
   end

   // R1, R7: a clear empties both words
   a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_hi == '0) && (acc_lo == '0));

   // R8: a load without clear writes the load values
   a_r8_load_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (acc_hi == $past(load_hi)) && (acc_lo == $past(load_lo)));

   // R9: idle cycles hold both words
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !clr && !load) |=> $stable(acc_hi) && $stable(acc_lo));

   // R3: saturating mode without overflow leaves the high word alone
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sat_mode && !ovf && !clr && !load) |=> $stable(acc_hi));

   // R4: positive overflow clamps to the largest value and flags
   a_r4_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sat_mode && ovf && !prod_neg && !clr && !load)
      |=> (acc_lo == POS_LIM) && acc_hi[0]
          && (acc_hi[ACC_W-1:1] == $past(acc_hi[ACC_W-1:1])));

   // R5: negative overflow clamps to the smallest value and flags
   a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sat_mode && ovf && prod_neg && !clr && !load)
      |=> (acc_lo == NEG_LIM) && acc_hi[0]
          && (acc_hi[ACC_W-1:1] == $past(acc_hi[ACC_W-1:1])));

   // R6: the sticky flag survives saturating operations and idle cycles
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hi[0] && !clr && !load && (sat_mode || !valid)) |=> acc_hi[0]);

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic             sat_mode,
   input  logic             acc_clr,
   input  logic             acc_load,
   input  logic [ACC_W-1:0] load_hi,
   input  logic [ACC_W-1:0] load_lo,
   output logic [ACC_W-1:0] acc_hi,
   output logic [ACC_W-1:0] acc_lo
);
   localparam int FULL_W = 2 * ACC_W;

   generate
      if (OP_W < 2) begin : g_bad_op
         $error("sat_mac_unit: OP_W must be at least 2");
      end
      if (ACC_W < 2 * OP_W) begin : g_bad_acc
         $error("sat_mac_unit: ACC_W must hold the full product");
      end
   endgenerate

   logic [ACC_W-1:0] prod_x, sum;
   logic             prod_neg, carry, ovf;

   mac_prod #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
      .op_a     (op_a),
      .op_b     (op_b),
      .prod_x   (prod_x),
      .prod_neg (prod_neg)
   );

   mac_lo_add #(.ACC_W(ACC_W)) u_add (
      .lo_old (acc_lo),
      .prod_x (prod_x),
      .sum    (sum),
      .carry  (carry),
      .ovf    (ovf)
   );

   mac_acc_regs #(.ACC_W(ACC_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (acc_clr),
      .load     (acc_load),
      .valid    (op_valid),
      .sat_mode (sat_mode),
      .load_hi  (load_hi),
      .load_lo  (load_lo),
      .sum      (sum),
      .carry    (carry),
      .ovf      (ovf),
      .prod_neg (prod_neg),
      .acc_hi   (acc_hi),
      .acc_lo   (acc_lo)
   );

   // R2, R10: wrap mode adds the sign-extended product to the 64-bit value
   logic signed [FULL_W-1:0] chk_prod;
   assign chk_prod = FULL_W'($signed(op_a)) * FULL_W'($signed(op_b));

   a_r2_wrap_accum: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !sat_mode && !acc_clr && !acc_load)
      |=> {acc_hi, acc_lo} == $past({acc_hi, acc_lo} + chk_prod));

endmodule

// File: tb/sat_mac_unit_tb_top.sv
module sat_mac_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid, sat_mode, acc_clr, acc_load;
   logic [15:0] op_a, op_b;
   logic [31:0] load_hi, load_lo, acc_hi, acc_lo;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_hi, m_lo;

   always #10 clk = ~clk;

   sat_mac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
      .sat_mode(sat_mode), .acc_clr(acc_clr), .acc_load(acc_load),
      .load_hi(load_hi), .load_lo(load_lo), .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   // {sat_mode, op_a, op_b}
   localparam int NVEC = 16;
   localparam logic [32:0] VEC [NVEC] = '{
      {1'b0, 16'h7FFF, 16'h7FFF}, {1'b0, 16'h8000, 16'h8000},
      {1'b0, 16'h8000, 16'h7FFF}, {1'b0, 16'hFFFF, 16'hFFFF},
      {1'b1, 16'h1234, 16'h0010}, {1'b1, 16'hFF00, 16'h0100},
      {1'b0, 16'hFFFF, 16'h0001}, {1'b0, 16'h8000, 16'h0001},
      {1'b1, 16'h0003, 16'hFFFD}, {1'b0, 16'h4000, 16'h8000},
      {1'b0, 16'h4000, 16'h8000}, {1'b1, 16'h0002, 16'h0005},
      {1'b0, 16'h0000, 16'h5555}, {1'b1, 16'hA5A5, 16'h5A5A},
      {1'b0, 16'h7FFF, 16'h8000}, {1'b1, 16'h0001, 16'h0001}
   };

   task automatic model_mac(input logic s, input logic [15:0] a, input logic [15:0] b);
      logic signed [63:0] p64;
      logic [31:0] p, sm;
      p64 = 64'($signed(a)) * 64'($signed(b));
      p   = p64[31:0];
      if (s) begin
         sm = m_lo + p;
         if ((p[31] == m_lo[31]) && (sm[31] != p[31])) begin
            m_hi = m_hi | 32'd1;
            m_lo = p[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
         end else begin
            m_lo = sm;
         end
      end else begin
         {m_hi, m_lo} = {m_hi, m_lo} + p64;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] eh, input logic [31:0] el);
      checks++;
      if (acc_hi !== eh || acc_lo !== el) begin
         fails++;
         $display("FAIL %s: got hi=%08h lo=%08h, expected hi=%08h lo=%08h",
                  req, acc_hi, acc_lo, eh, el);
      end
   endtask

   task automatic idle();
      op_valid = 1'b0; acc_clr = 1'b0; acc_load = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); idle(); acc_clr = 1'b1;
      @(negedge clk); idle();
      m_hi = '0; m_lo = '0;
   endtask

   task automatic do_load(input logic [31:0] h, input logic [31:0] l);
      @(negedge clk); idle(); acc_load = 1'b1; load_hi = h; load_lo = l;
      @(negedge clk); idle();
      m_hi = h; m_lo = l;
   endtask

   task automatic do_mac(input logic s, input logic [15:0] a, input logic [15:0] b);
      @(negedge clk); idle(); op_valid = 1'b1; sat_mode = s; op_a = a; op_b = b;
      @(negedge clk); idle();
      model_mac(s, a, b);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : stim
      rst_n = 1'b0; idle(); sat_mode = 1'b0;
      op_a = '0; op_b = '0; load_hi = '0; load_lo = '0;
      m_hi = '0; m_lo = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset", 32'h0, 32'h0);
      rst_n = 1'b1;

      // R10: table walked with back-to-back strobes, R2/R3 via model
      @(negedge clk);
      for (int i = 0; i < NVEC; i++) begin
         op_valid = 1'b1; sat_mode = VEC[i][32]; op_a = VEC[i][31:16]; op_b = VEC[i][15:0];
         model_mac(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
         @(negedge clk);
         chk(VEC[i][32] ? "R10/R3 table" : "R10/R2 table", m_hi, m_lo);
      end
      idle();

      // R9: garbage operands without strobe
      op_a = 16'h7FFF; op_b = 16'h7FFF; sat_mode = 1'b0; load_hi = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      chk("R9 idle hold", m_hi, m_lo);

      // R2: corner products from zero
      do_clear();
      do_mac(1'b0, 16'h8000, 16'h8000); chk("R2 8000*8000", 32'h0, 32'h4000_0000);
      do_clear();
      do_mac(1'b0, 16'h7FFF, 16'h7FFF); chk("R2 7FFF*7FFF", 32'h0, 32'h3FFF_0001);
      do_clear();
      do_mac(1'b0, 16'hFFFF, 16'h0001); chk("R2 negative sign-extends", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      do_load(32'h0, 32'hFFFF_FFFF);
      do_mac(1'b0, 16'h0001, 16'h0001); chk("R2 carry into high", 32'h1, 32'h0);

      // R3: saturating, no overflow
      do_load(32'h1234_5678, 32'h10);
      do_mac(1'b1, 16'h0002, 16'h0003); chk("R3 high unchanged", 32'h1234_5678, 32'h16);

      // R4: positive overflow by repeated accumulation
      do_clear();
      do_mac(1'b1, 16'h8000, 16'h8000); chk("R4 first step", 32'h0, 32'h4000_0000);
      do_mac(1'b1, 16'h8000, 16'h8000); chk("R4 positive clamp", 32'h1, 32'h7FFF_FFFF);

      // R6: sticky through a non-overflowing op and idle
      do_mac(1'b1, 16'hFFFF, 16'h0001); chk("R6 sticky kept", 32'h1, 32'h7FFF_FFFE);
      repeat (2) @(negedge clk);
      chk("R6 sticky idle", 32'h1, 32'h7FFF_FFFE);

      // R5: negative overflow from a preset near the limit
      do_load(32'hABCD_0000, 32'h8000_0010);
      do_mac(1'b1, 16'h8000, 16'h7FFF); chk("R5 negative clamp", 32'hABCD_0001, 32'h8000_0000);

      // R7: clear wins over load and strobe
      @(negedge clk); idle();
      acc_clr = 1'b1; acc_load = 1'b1; op_valid = 1'b1; load_hi = 32'h5; load_lo = 32'h6;
      @(negedge clk); idle(); m_hi = '0; m_lo = '0;
      chk("R7 clear priority", 32'h0, 32'h0);

      // R8: load wins over strobe
      @(negedge clk); idle();
      acc_load = 1'b1; op_valid = 1'b1; sat_mode = 1'b0; op_a = 16'h0100; op_b = 16'h0100;
      load_hi = 32'hCAFE_0000; load_lo = 32'h0000_BEEF;
      @(negedge clk); idle();
      chk("R8 load priority", 32'hCAFE_0000, 32'h0000_BEEF);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule